// File: doc/BRIEF.md
# DMA Channel Command and State Controller

This block holds the command/status register and the state machine of one DMA channel. It serves either the transfer side or the event side of a DMA engine. Software writes a command code into one byte of the channel's control word. The block then moves the channel through its states and reports the current state in another byte of the same word. A doorbell unit supplies a work-pending level, and the channel moves between an idle-enabled state and a running state as that level changes. The datapath supplies a quiesce-done level. Reset and suspend wait for that level so that a transfer already in flight is allowed to finish. A separate manager input can force the channel into a stopped state, and only a software reset brings it out.

The outputs are the state code, a run enable that lets the datapath start new work, and a one-cycle pulse that tells the datapath to reset itself. Descriptor fetch and data movement are handled elsewhere.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the state code is 0 (disabled), `run_en` and `rst_pulse` are low, and the whole status word is zero.
- R2: Only a write with `wr_en` high to offset 0 is decoded, and the command code is taken from bits 23:16 of `wr_data`. A write to any other offset has no effect on state, pulse or status word.
- R3: The status word has the state code in bits 15:8 and the last defined command code written in bits 23:16. All other bits read zero.
- R4: Enable (code 1), accepted in disabled (0) or suspended (3), gives state 1 (enabled) in the next cycle if `work_pending` is low, or state 2 (running) if it is high. `run_en` is high in both of these states.
- R5: While the channel is enabled or running and no operation is pending, the state follows `work_pending` with a one-cycle lag: 2 when it is high, 1 when it is low.
- R6: Suspend (code 2) from enabled or running drops `run_en` in the next cycle. The state code then stays frozen until `quiesce_done` is sampled high, and it reads 3 (suspended) in the following cycle. Suspend in the disabled state is ignored.
- R7: Reset (code 9) gives a `rst_pulse` exactly one cycle long, starting the cycle after the write, and holds `run_en` low. The state is kept until `quiesce_done` is sampled high, and then it becomes 0. Reset is accepted from every state, including stopped.
- R8: Disable (code 0) gives state 0 in the next cycle from enabled, running or suspended. In the stopped state it is ignored.
- R9: While `stop_req` is high, the state becomes 4 (stopped) in the next cycle, pending operations are dropped, `run_en` is low and every command is ignored. After `stop_req` falls, the state stays 4 until a reset completes.
- R10: A command code other than 0, 1, 2 or 9 is ignored. It changes neither the state nor the command field of the status word.
- R11: While a reset is pending, all commands are ignored. While a suspend is pending, only disable and reset are acted on: disable ends the channel in state 0, and reset replaces the suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data; the command code is in bits 23:16 |
| work_pending | input | 1 | Doorbell logic has descriptors outstanding |
| quiesce_done | input | 1 | Datapath has no transfer in flight |
| stop_req | input | 1 | Manager request to force the stopped state |
| status_word | output | 32 | Control/status readback |
| state | output | 8 | Current state code |
| run_en | output | 1 | Datapath may start new work |
| rst_pulse | output | 1 | One-cycle datapath reset request |

## Verification
The state code is a register that drives the status word directly. A wrong transition therefore shows at the ports on the first sample after the clock edge that caused it. A pending-operation flag that is wrong internally cannot be seen in the state byte. It shows up as `run_en` being high while a suspend or reset is outstanding, or as a command that should be blocked taking effect. The directed scenarios issue commands during pending windows to expose exactly that. A wrong `rst_pulse` length, or a pulse fired by a blocked reset, shows in the cycle after the write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int FIELD_W = 8;

  typedef enum logic [FIELD_W-1:0] {
    ST_OFF  = 8'd0,
    ST_IDLE = 8'd1,
    ST_RUN  = 8'd2,
    ST_HELD = 8'd3,
    ST_STOP = 8'd4
  } chan_state_e;

  typedef enum logic [FIELD_W-1:0] {
    CMD_OFF   = 8'd0,
    CMD_ON    = 8'd1,
    CMD_PAUSE = 8'd2,
    CMD_RESET = 8'd9
  } chan_cmd_e;

endpackage

// File: rtl/dcc_rst_sync.sv
module dcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dcc_cmd_decode.sv
module dcc_cmd_decode
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CSR_OFFSET = 0,
  parameter int CMD_LSB    = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_hit,
  output logic              cmd_vld,
  output chan_cmd_e         cmd_code
);

  localparam logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(CSR_OFFSET);

  logic [FIELD_W-1:0] raw_code;
  logic               unused_wr_bits;

  assign wr_hit         = wr_en && (wr_addr == CSR_ADDR);
  assign raw_code       = wr_data[CMD_LSB +: FIELD_W];
  assign unused_wr_bits = ^wr_data;

  always_comb begin
    cmd_vld  = 1'b0;
    cmd_code = CMD_OFF;
    if (wr_hit) begin
      case (raw_code)
        8'd0: begin cmd_vld = 1'b1; cmd_code = CMD_OFF;   end
        8'd1: begin cmd_vld = 1'b1; cmd_code = CMD_ON;    end
        8'd2: begin cmd_vld = 1'b1; cmd_code = CMD_PAUSE; end
        8'd9: begin cmd_vld = 1'b1; cmd_code = CMD_RESET; end
        default: begin cmd_vld = 1'b0; cmd_code = CMD_OFF; end
      endcase
    end
  end

endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_vld,
  input  chan_cmd_e   cmd_code,
  input  logic        work_pending,
  input  logic        quiesce_done,
  input  logic        stop_req,
  output chan_state_e state_q,
  output logic        run_en,
  output logic        rst_pulse
);

  chan_state_e state_d;
  logic        rst_pend_q, rst_pend_d;
  logic        sus_pend_q, sus_pend_d;
  logic        pulse_q, pulse_d;
  logic        active;
  logic        is_reset, is_off, is_on, is_pause;

  assign active   = (state_q == ST_IDLE) || (state_q == ST_RUN);
  assign is_reset = cmd_vld && (cmd_code == CMD_RESET);
  assign is_off   = cmd_vld && (cmd_code == CMD_OFF);
  assign is_on    = cmd_vld && (cmd_code == CMD_ON);
  assign is_pause = cmd_vld && (cmd_code == CMD_PAUSE);

  always_comb begin
    state_d    = state_q;
    rst_pend_d = rst_pend_q;
    sus_pend_d = sus_pend_q;
    pulse_d    = 1'b0;
    if (stop_req) begin
      state_d    = ST_STOP;
      rst_pend_d = 1'b0;
      sus_pend_d = 1'b0;
    end else if (rst_pend_q) begin
      if (quiesce_done) begin
        state_d    = ST_OFF;
        rst_pend_d = 1'b0;
      end
    end else if (is_reset) begin
      rst_pend_d = 1'b1;
      sus_pend_d = 1'b0;
      pulse_d    = 1'b1;
    end else if (sus_pend_q) begin
      if (is_off) begin
        state_d    = ST_OFF;
        sus_pend_d = 1'b0;
      end else if (quiesce_done) begin
        state_d    = ST_HELD;
        sus_pend_d = 1'b0;
      end
    end else if (is_off && (state_q != ST_STOP)) begin
      state_d = ST_OFF;
    end else if (is_on && ((state_q == ST_OFF) || (state_q == ST_HELD))) begin
      state_d = work_pending ? ST_RUN : ST_IDLE;
    end else if (is_pause && active) begin
      sus_pend_d = 1'b1;
    end else if (active) begin
      state_d = work_pending ? ST_RUN : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OFF;
      rst_pend_q <= 1'b0;
      sus_pend_q <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      rst_pend_q <= rst_pend_d;
      sus_pend_q <= sus_pend_d;
      pulse_q    <= pulse_d;
    end
  end

  assign run_en    = active && !rst_pend_q && !sus_pend_q;
  assign rst_pulse = pulse_q;

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  assert_pulse_gates_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> !run_en);

  assert_stop_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (state_q == ST_STOP));

  assert_run_only_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> ((state_q == ST_IDLE) || (state_q == ST_RUN)));

  assert_held_after_quiesce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HELD) && ($past(state_q) != ST_HELD)) |-> $past(quiesce_done));

  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {ST_OFF, ST_IDLE, ST_RUN, ST_HELD, ST_STOP});

endmodule

// File: rtl/dcc_status.sv
module dcc_status
  import dma_chan_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CMD_LSB   = 16,
  parameter int STATE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  chan_cmd_e         cmd_code,
  input  chan_state_e       state_q,
  output logic [DATA_W-1:0] status_word
);

  chan_cmd_e last_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_cmd_q <= CMD_OFF;
    else if (cmd_vld) last_cmd_q <= cmd_code;
  end

  always_comb begin
    status_word                        = '0;
    status_word[CMD_LSB +: FIELD_W]    = last_cmd_q;
    status_word[STATE_LSB +: FIELD_W]  = state_q;
  end

  assert_cmd_field_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> (status_word[CMD_LSB +: FIELD_W] == $past(status_word[CMD_LSB +: FIELD_W])));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CSR_OFFSET = 0,
  parameter int CMD_LSB    = 16,
  parameter int STATE_LSB  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              work_pending,
  input  logic              quiesce_done,
  input  logic              stop_req,
  output logic [DATA_W-1:0] status_word,
  output logic [7:0]        state,
  output logic              run_en,
  output logic              rst_pulse
);

  logic        rst_n_i;
  logic        wr_hit;
  logic        cmd_vld;
  chan_cmd_e   cmd_code;
  chan_state_e state_q;

  dcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dcc_cmd_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CSR_OFFSET (CSR_OFFSET),
    .CMD_LSB    (CMD_LSB)
  ) u_decode (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_hit   (wr_hit),
    .cmd_vld  (cmd_vld),
    .cmd_code (cmd_code)
  );

  dcc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .cmd_vld      (cmd_vld),
    .cmd_code     (cmd_code),
    .work_pending (work_pending),
    .quiesce_done (quiesce_done),
    .stop_req     (stop_req),
    .state_q      (state_q),
    .run_en       (run_en),
    .rst_pulse    (rst_pulse)
  );

  dcc_status #(
    .DATA_W    (DATA_W),
    .CMD_LSB   (CMD_LSB),
    .STATE_LSB (STATE_LSB)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .cmd_vld     (cmd_vld),
    .cmd_code    (cmd_code),
    .state_q     (state_q),
    .status_word (status_word)
  );

  assign state = state_q;

  assert_undefined_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_hit && !cmd_vld && (state_q == ST_OFF) && !stop_req) |=> (state_q == ST_OFF));

endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic        work_pending;
  logic        quiesce_done;
  logic        stop_req;
  logic [31:0] status_word;
  logic [7:0]  state;
  logic        run_en;
  logic        rst_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl u_dma_chan_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .work_pending (work_pending),
    .quiesce_done (quiesce_done),
    .stop_req     (stop_req),
    .status_word  (status_word),
    .state        (state),
    .run_en       (run_en),
    .rst_pulse    (rst_pulse)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] addr, input logic [7:0] code);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = addr;
    wr_data = {8'h00, code, 16'h0000};
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
    wr_addr = '0;
  endtask

  task automatic quiesce();
    @(negedge clk) quiesce_done = 1'b1;
    @(negedge clk) quiesce_done = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 state", {24'h0, state}, 32'd0);
    chk("R1 run_en", {31'h0, run_en}, 32'd0);
    chk("R1 rst_pulse", {31'h0, rst_pulse}, 32'd0);
    chk("R1 status word", status_word, 32'h0);
  endtask

  task automatic t_enable_and_track();
    work_pending = 1'b0;
    wr(12'h000, 8'd1);
    chk("R4 enable idle state", {24'h0, state}, 32'd1);
    chk("R4 run_en", {31'h0, run_en}, 32'd1);
    chk("R3 status word layout", status_word, 32'h0001_0100);
    work_pending = 1'b1;
    tick(1);
    chk("R5 running on work", {24'h0, state}, 32'd2);
    chk("R3 running readback", status_word, 32'h0001_0200);
    work_pending = 1'b0;
    tick(1);
    chk("R5 back to enabled", {24'h0, state}, 32'd1);
  endtask

  task automatic t_ignored_writes();
    wr(12'h000, 8'd7);
    chk("R10 undefined code state", {24'h0, state}, 32'd1);
    chk("R10 undefined code cmd field", status_word, 32'h0001_0100);
    wr(12'h004, 8'd9);
    chk("R2 other offset no pulse", {31'h0, rst_pulse}, 32'd0);
    chk("R2 other offset status", status_word, 32'h0001_0100);
  endtask

  task automatic t_suspend();
    work_pending = 1'b1;
    tick(1);
    wr(12'h000, 8'd2);
    chk("R6 run_en drops", {31'h0, run_en}, 32'd0);
    chk("R6 state frozen", {24'h0, state}, 32'd2);
    work_pending = 1'b0;
    tick(2);
    chk("R6 still frozen", {24'h0, state}, 32'd2);
    wr(12'h000, 8'd1);
    chk("R11 enable blocked in suspend", {24'h0, state}, 32'd2);
    chk("R11 run_en stays low", {31'h0, run_en}, 32'd0);
    quiesce();
    chk("R6 suspended", {24'h0, state}, 32'd3);
    chk("R6 run_en low suspended", {31'h0, run_en}, 32'd0);
    work_pending = 1'b1;
    wr(12'h000, 8'd1);
    chk("R4 resume running", {24'h0, state}, 32'd2);
    chk("R4 resume run_en", {31'h0, run_en}, 32'd1);
    work_pending = 1'b0;
  endtask

  task automatic t_disable();
    wr(12'h000, 8'd0);
    chk("R8 disable", {24'h0, state}, 32'd0);
    chk("R8 run_en", {31'h0, run_en}, 32'd0);
    wr(12'h000, 8'd2);
    chk("R6 suspend ignored when off", {24'h0, state}, 32'd0);
  endtask

  task automatic t_reset_cmd();
    wr(12'h000, 8'd1);
    wr(12'h000, 8'd9);
    chk("R7 pulse high", {31'h0, rst_pulse}, 32'd1);
    chk("R7 run_en low", {31'h0, run_en}, 32'd0);
    chk("R7 state kept", {24'h0, state}, 32'd1);
    tick(1);
    chk("R7 pulse one cycle", {31'h0, rst_pulse}, 32'd0);
    wr(12'h000, 8'd1);
    chk("R11 blocked during reset", {24'h0, state}, 32'd1);
    chk("R11 run_en low in reset", {31'h0, run_en}, 32'd0);
    quiesce();
    chk("R7 disabled after quiesce", {24'h0, state}, 32'd0);
  endtask

  task automatic t_stop();
    wr(12'h000, 8'd1);
    stop_req = 1'b1;
    tick(1);
    chk("R9 stopped", {24'h0, state}, 32'd4);
    chk("R9 run_en", {31'h0, run_en}, 32'd0);
    wr(12'h000, 8'd9);
    chk("R9 reset ignored while stop", {31'h0, rst_pulse}, 32'd0);
    stop_req = 1'b0;
    tick(2);
    chk("R9 sticky", {24'h0, state}, 32'd4);
    wr(12'h000, 8'd1);
    chk("R9 enable ignored", {24'h0, state}, 32'd4);
    wr(12'h000, 8'd0);
    chk("R8 disable ignored in stopped", {24'h0, state}, 32'd4);
    wr(12'h000, 8'd9);
    chk("R7 reset from stopped pulse", {31'h0, rst_pulse}, 32'd1);
    quiesce();
    chk("R7 stopped to disabled", {24'h0, state}, 32'd0);
  endtask

  task automatic t_disable_in_suspend();
    wr(12'h000, 8'd1);
    wr(12'h000, 8'd2);
    chk("R6 pending run_en", {31'h0, run_en}, 32'd0);
    wr(12'h000, 8'd0);
    chk("R11 disable during suspend", {24'h0, state}, 32'd0);
    wr(12'h000, 8'd1);
    chk("R11 no stale pending", {31'h0, run_en}, 32'd1);
    wr(12'h000, 8'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    work_pending = 1'b0; quiesce_done = 1'b0; stop_req = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset_state();
    t_enable_and_track();
    t_ignored_writes();
    t_suspend();
    t_disable();
    t_reset_cmd();
    t_stop();
    t_disable_in_suspend();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule